// File: doc/BRIEF.md
# Serial-Clocked Byte Memory Slave

This block is a serial-bus slave that exposes an 8192-byte read/write store over a four-wire SPI link. A frame opens when chip select falls and closes when it rises. The first byte is a command. Memory commands are followed by a two-byte address, and then by any number of data bytes. The address counter steps once per data byte, so a single frame can stream through the whole array and wrap around. The block also holds a one-byte status register with a write-enable latch and a protect-enable bit. An external write-protect pin can lock the status register.

All pins are sampled in the block's own system clock domain through synchronizers. The serial clock must therefore run well below the system clock; the bench uses twelve system cycles per serial bit. The serial clock may idle low (mode 0) or high (mode 3), and no configuration is needed to select between them. A hold input pauses a frame in mid-byte without deselecting the device. Writes finish with no busy time.

Top module: `spi_mem`

## Requirements
- R1: The address is 13 bits, taken from the low 5 bits of the first address byte and all 8 bits of the second. The top 3 bits of the first address byte are ignored.
- R2: While cs_n is high, so_oe is low. Serial clock and data activity while deselected changes neither memory nor status.
- R3: A frame starts at the falling edge of cs_n, and its first byte is the command. The command codes are 0x06 set-write-enable, 0x04 clear-write-enable, 0x05 status read, 0x01 status write, 0x03 memory read and 0x02 memory write.
- R4: si is sampled on rising serial clock edges and so changes only after falling edges. Every byte travels most significant bit first.
- R5: Frames behave identically whether the serial clock idles low or high when cs_n falls. The idle level never counts as an edge.
- R6: While hold_n is low inside a frame, so_oe is low and serial clock and data are ignored. When hold_n returns high, the transfer continues at the bit where it stopped.
- R7: The status byte has the write-enable latch at bit 1 and protect-enable at bit 7; all other bits read 0. Memory and status writes take effect only while the latch is set. The latch clears when cs_n rises at the end of any memory-write or status-write frame.
- R8: A status write leaves protect-enable unchanged when wp_n is low and protect-enable is 1.
- R9: The address steps by one after each data byte, read or write, and wraps from 0x1FFF to 0x0000.
- R10: A data byte cut short by cs_n rising before its eighth bit is discarded.
- R11: After an unknown command byte, the rest of the frame is ignored: no write occurs and so_oe stays low.
- R12: A write is visible to a read in the very next frame, with no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, either idle level |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Status write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means so is to be high-impedance |

## Verification
The assertions assume three things about the serial inputs. First, sck, si and hold_n change slowly compared with clk, so that each serial edge is seen as one clean transition after the synchronizers. Second, hold_n only changes while sck is at its low level. Third, chip select is not released in the same system cycle as a serial edge. The bench drives every serial pin from tasks clocked on the falling edge of clk and holds each level for six system cycles. It puts hold transitions inside the low phase of sck and leaves several cycles of quiet around each cs_n transition, so the stimulus stays inside these assumptions.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] CMD_WEN_SET = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD = 8'h05;
  localparam logic [7:0] CMD_STAT_WR = 8'h01;
  localparam logic [7:0] CMD_MEM_RD  = 8'h03;
  localparam logic [7:0] CMD_MEM_WR  = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADR_HI,
    PH_ADR_LO,
    PH_MEM_RD,
    PH_MEM_WR,
    PH_STAT_RD,
    PH_STAT_WR,
    PH_DROP
  } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic frame_start,
  output logic frame_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic wp_s
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] PIN_RST = 5'b11100;

  logic [NPIN-1:0] raw, synced;
  logic cs_s, hold_s, sck_s;
  logic cs_q, sck_q;
  logic active;

  assign raw = {cs_n, hold_n, wp_n, sck, si};

  spi_mem_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign {cs_s, hold_s, wp_s, sck_s, si_s} = synced;

  // the previous clock level is tracked at all times, so whatever level
  // sck idles at when select falls is never taken as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign active      = !cs_s && !cs_q && hold_s;
  assign frame_start = !cs_s && cs_q;
  assign frame_end   = cs_s && !cs_q;
  assign sck_rise    = active && sck_s && !sck_q;
  assign sck_fall    = active && !sck_s && sck_q;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              wp_s,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              so_q,
  output logic              tx_live,
  output logic              wpen
);
  localparam int HI_W = ADDR_W - 8;

  phase_e            phase;
  logic [2:0]        bit_idx;
  logic [6:0]        rx_sh;
  logic [7:0]        rx_byte;
  logic [7:0]        tx_sh;
  logic [7:0]        tx_src;
  logic [7:0]        status;
  logic [ADDR_W-1:0] addr;
  logic              wel;
  logic              is_read;
  logic              wr_frame;
  logic              byte_done;
  logic              stat_lock;

  assign rx_byte   = {rx_sh, si_s};
  assign byte_done = sck_rise && (bit_idx == 3'd7);
  assign status    = {wpen, 5'b00000, wel, 1'b0};
  assign stat_lock = wpen && !wp_s;
  assign tx_src    = (phase == PH_MEM_RD) ? mem_rdata : status;

  assign mem_addr  = addr;
  assign mem_wdata = rx_byte;
  assign mem_we    = byte_done && (phase == PH_MEM_WR) && wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_idx  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      so_q     <= 1'b0;
      tx_live  <= 1'b0;
      addr     <= '0;
      wel      <= 1'b0;
      wpen     <= 1'b0;
      is_read  <= 1'b0;
      wr_frame <= 1'b0;
    end else if (frame_start) begin
      phase    <= PH_CMD;
      bit_idx  <= '0;
      tx_live  <= 1'b0;
      wr_frame <= 1'b0;
    end else if (frame_end) begin
      phase   <= PH_IDLE;
      tx_live <= 1'b0;
      if (wr_frame) wel <= 1'b0;
    end else begin
      if (sck_rise && phase != PH_IDLE) begin
        rx_sh   <= rx_byte[6:0];
        bit_idx <= bit_idx + 3'd1;
      end
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            unique case (rx_byte)
              CMD_WEN_SET: begin wel <= 1'b1; phase <= PH_DROP; end
              CMD_WEN_CLR: begin wel <= 1'b0; phase <= PH_DROP; end
              CMD_STAT_RD: phase <= PH_STAT_RD;
              CMD_STAT_WR: begin phase <= PH_STAT_WR; wr_frame <= 1'b1; end
              CMD_MEM_RD:  begin phase <= PH_ADR_HI; is_read <= 1'b1; end
              CMD_MEM_WR:  begin
                phase    <= PH_ADR_HI;
                is_read  <= 1'b0;
                wr_frame <= 1'b1;
              end
              default:     phase <= PH_DROP;
            endcase
          end
          PH_ADR_HI: begin
            addr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
            phase <= PH_ADR_LO;
          end
          PH_ADR_LO: begin
            addr[7:0] <= rx_byte;
            phase <= is_read ? PH_MEM_RD : PH_MEM_WR;
          end
          PH_MEM_RD, PH_MEM_WR: addr <= addr + 1'b1;
          PH_STAT_WR: if (wel && !stat_lock) wpen <= rx_byte[7];
          default: ;
        endcase
      end
      if (sck_fall && (phase == PH_MEM_RD || phase == PH_STAT_RD)) begin
        if (bit_idx == 3'd0) begin
          so_q    <= tx_src[7];
          tx_sh   <= {tx_src[6:0], 1'b0};
          tx_live <= 1'b1;
        end else begin
          so_q  <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem.sv
module spi_mem #(
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  logic frame_start, frame_end, sck_rise, sck_fall;
  logic si_s, wp_s;
  logic mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic so_q, tx_live, wpen;

  spi_mem_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .wp_s(wp_s)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .wp_s(wp_s),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .so_q(so_q), .tx_live(tx_live), .wpen(wpen)
  );

  spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  assign so    = so_q;
  assign so_oe = !cs_n && hold_n && tx_live;
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic so,
  input logic so_oe,
  input logic sck_fall,
  input logic wpen,
  input logic wp_s
);
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);

  assert_so_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (so != $past(so)) |-> $past(sck_fall));

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !hold_n) |-> !so_oe);

  assert_protect_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_s) |=> wpen);
endmodule

bind spi_mem spi_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so(so),
  .so_oe(so_oe), .sck_fall(sck_fall), .wpen(wpen), .wp_s(wp_s)
);

// File: tb/tb_spi_mem.sv
module tb_spi_mem;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic cpol = 1'b0;
  logic done = 1'b0;
  int total = 0, bad = 0;
  logic [7:0] rbuf [4];

  always #5 clk = ~clk;

  spi_mem dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
               .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sck = 1'b0; si = b; half();
    r = so;
    sck = 1'b1; half();
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic open_frame();
    sck = cpol; half();
    cs_n = 1'b0; half();
  endtask

  task automatic close_frame();
    sck = cpol; half();
    cs_n = 1'b1; half(); half();
  endtask

  task automatic cmd_only(input logic [7:0] c);
    logic [7:0] d;
    open_frame(); byte_x(c, d); close_frame();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] d;
    open_frame(); byte_x(8'h05, d); byte_x(8'h00, s); close_frame();
  endtask

  task automatic write_status(input logic [7:0] v);
    logic [7:0] d;
    open_frame(); byte_x(8'h01, d); byte_x(v, d); close_frame();
  endtask

  task automatic mem_write(input logic [7:0] ahi, input logic [7:0] alo,
                           input int n, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] d;
    logic [7:0] v [3];
    v[0] = b0; v[1] = b1; v[2] = b2;
    open_frame();
    byte_x(8'h02, d); byte_x(ahi, d); byte_x(alo, d);
    for (int i = 0; i < n; i++) byte_x(v[i], d);
    close_frame();
  endtask

  task automatic mem_read(input logic [7:0] ahi, input logic [7:0] alo,
                          input int n);
    logic [7:0] d;
    open_frame();
    byte_x(8'h03, d); byte_x(ahi, d); byte_x(alo, d);
    for (int i = 0; i < n; i++) byte_x(8'h00, rbuf[i]);
    close_frame();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R2", "so_oe after reset", {31'd0, so_oe}, 32'd0);
    read_status(s);
    chk("R7", "status after reset", {24'd0, s}, 32'h00);
  endtask

  task automatic t_basic();
    logic [7:0] s;
    cmd_only(8'h06);
    read_status(s);
    chk("R3", "status after set-write-enable", {24'd0, s}, 32'h02);
    // high address byte 0xE1: top 3 bits dropped, address 0x0123
    mem_write(8'hE1, 8'h23, 3, 8'h3C, 8'h81, 8'hF0);
    read_status(s);
    chk("R7", "latch clears after write frame", {24'd0, s}, 32'h00);
    mem_read(8'h01, 8'h23, 3);
    chk("R1", "byte at 0x0123", {24'd0, rbuf[0]}, 32'h3C);
    chk("R4", "second byte msb first", {24'd0, rbuf[1]}, 32'h81);
    chk("R9", "third byte increments", {24'd0, rbuf[2]}, 32'hF0);
    mem_read(8'h01, 8'h24, 1);
    chk("R12", "direct read mid-run", {24'd0, rbuf[0]}, 32'h81);
  endtask

  task automatic t_mode3_wrap();
    logic [7:0] s;
    cpol = 1'b1;
    sck = 1'b1; half();
    cmd_only(8'h06);
    read_status(s);
    chk("R5", "status in mode 3", {24'd0, s}, 32'h02);
    mem_write(8'h1F, 8'hFF, 2, 8'h55, 8'hAA, 8'h00);
    mem_read(8'h1F, 8'hFF, 2);
    chk("R5", "mode 3 byte at 0x1FFF", {24'd0, rbuf[0]}, 32'h55);
    chk("R9", "wrap to 0x0000", {24'd0, rbuf[1]}, 32'hAA);
    cpol = 1'b0;
    sck = 1'b0; half();
    mem_read(8'h00, 8'h00, 1);
    chk("R9", "0x0000 holds wrapped write", {24'd0, rbuf[0]}, 32'hAA);
  endtask

  task automatic t_no_latch();
    cmd_only(8'h06);
    mem_write(8'h00, 8'h10, 1, 8'h11, 8'h00, 8'h00);
    mem_write(8'h00, 8'h10, 1, 8'h77, 8'h00, 8'h00);
    mem_read(8'h00, 8'h10, 1);
    chk("R7", "write without latch ignored", {24'd0, rbuf[0]}, 32'h11);
    cmd_only(8'h06);
    cmd_only(8'h04);
    mem_write(8'h00, 8'h10, 1, 8'h99, 8'h00, 8'h00);
    mem_read(8'h00, 8'h10, 1);
    chk("R7", "write after clear-enable ignored", {24'd0, rbuf[0]}, 32'h11);
  endtask

  task automatic t_deselect();
    logic [7:0] s;
    int oe_seen = 0;
    cmd_only(8'h06);
    for (int i = 0; i < 32; i++) begin
      si = i[0] ^ i[2]; sck = ~sck; half();
      if (so_oe) oe_seen++;
    end
    sck = 1'b0; half();
    chk("R2", "so_oe while deselected", oe_seen, 0);
    read_status(s);
    chk("R2", "status untouched by idle clocks", {24'd0, s}, 32'h02);
    cmd_only(8'h04);
    mem_read(8'h00, 8'h10, 1);
    chk("R2", "memory untouched by idle clocks", {24'd0, rbuf[0]}, 32'h11);
  endtask

  task automatic t_hold();
    logic [7:0] d, tx, rx;
    logic r;
    int oe_seen = 0;
    cmd_only(8'h06);
    tx = 8'hC3;
    open_frame();
    byte_x(8'h02, d); byte_x(8'h02, d); byte_x(8'h00, d);
    for (int i = 7; i >= 4; i--) bit_x(tx[i], r);
    sck = 1'b0; half();
    hold_n = 1'b0; half();
    for (int i = 0; i < 6; i++) begin
      si = i[0]; sck = ~sck; half();
    end
    hold_n = 1'b1; half();
    for (int i = 3; i >= 0; i--) bit_x(tx[i], r);
    close_frame();
    // read with a pause inside the data byte
    open_frame();
    byte_x(8'h03, d); byte_x(8'h02, d); byte_x(8'h00, d);
    for (int i = 7; i >= 5; i--) bit_x(1'b0, rx[i]);
    sck = 1'b0; half();
    hold_n = 1'b0; half();
    for (int i = 0; i < 4; i++) begin
      sck = ~sck; half();
      if (so_oe) oe_seen++;
    end
    hold_n = 1'b1; half();
    for (int i = 4; i >= 0; i--) bit_x(1'b0, rx[i]);
    chk("R6", "so_oe during read", {31'd0, so_oe}, 32'd1);
    close_frame();
    chk("R6", "so_oe while held", oe_seen, 0);
    chk("R6", "read across hold", {24'd0, rx}, 32'hC3);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    cmd_only(8'h06);
    write_status(8'h80);
    read_status(s);
    chk("R7", "protect-enable set, latch cleared", {24'd0, s}, 32'h80);
    wp_n = 1'b0;
    cmd_only(8'h06);
    write_status(8'h00);
    read_status(s);
    chk("R8", "status locked by pin", {24'd0, s}, 32'h80);
    wp_n = 1'b1;
    cmd_only(8'h06);
    write_status(8'h00);
    read_status(s);
    chk("R8", "status free once pin high", {24'd0, s}, 32'h00);
  endtask

  task automatic t_partial();
    logic [7:0] d;
    logic r;
    cmd_only(8'h06);
    mem_write(8'h03, 8'h00, 2, 8'h00, 8'h00, 8'h00);
    cmd_only(8'h06);
    open_frame();
    byte_x(8'h02, d); byte_x(8'h03, d); byte_x(8'h00, d);
    byte_x(8'h5A, d);
    for (int i = 0; i < 5; i++) bit_x(1'b1, r);
    close_frame();
    mem_read(8'h03, 8'h00, 2);
    chk("R10", "full byte kept", {24'd0, rbuf[0]}, 32'h5A);
    chk("R10", "partial byte dropped", {24'd0, rbuf[1]}, 32'h00);
  endtask

  task automatic t_unknown();
    logic [7:0] d, s;
    int oe_seen = 0;
    cmd_only(8'h06);
    open_frame();
    byte_x(8'h0B, d);
    byte_x(8'h02, d); byte_x(8'h00, d); byte_x(8'h00, d); byte_x(8'hFF, d);
    if (so_oe) oe_seen++;
    close_frame();
    chk("R11", "so_oe after unknown command", oe_seen, 0);
    mem_read(8'h00, 8'h00, 1);
    chk("R11", "no write after unknown command", {24'd0, rbuf[0]}, 32'hAA);
    read_status(s);
    chk("R11", "latch kept after unknown command", {24'd0, s}, 32'h02);
    cmd_only(8'h04);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_mode3_wrap();
    t_no_latch();
    t_deselect();
    t_hold();
    t_protect();
    t_partial();
    t_unknown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule